// File: doc/BRIEF.md
# Product-Term Sharing Ring

This block steers product-term results between neighbouring logic cells so that a cell needing a wide sum-of-products can borrow terms from the cells beside it. Every cell supplies two groups of four product-term results. A two-bit route code for each group keeps the group with its owner, hands it to the owner's next neighbour, hands it to the previous neighbour, or parks it so that it drives nothing. Each cell's output is the OR of every term in every group that reaches it. The result is registered once.

Cells form two independent rings that wrap around. The neighbour relation comes from a constant map chosen by a parameter. The sequential layout links each cell to the next index. The folded layout, used for 12-cell rings, walks the first half of the ring downwards and the second half upwards. Product-term generation and the cell registers that consume the sums lie outside this block.

Top module: `ptal_alloc_ring`

## Requirements
- R1: While `rst_ni` is low, `sum_o` is all zeros whatever the inputs.
- R2: `sum_o` is registered. The value present after a rising clock edge reflects `pt_i` and `cfg_i` as sampled at that edge. Input changes between edges do not reach `sum_o`.
- R3: Route code 2'b00 (keep) makes a group feed its owning cell's sum. Cell k's group g occupies `pt_i[k*8+g*4 +: 4]`, and its route code is `cfg_i[k*4+g*2 +: 2]`.
- R4: Route code 2'b01 makes a group feed the sum of the owning cell's next neighbour and no longer feed its owner.
- R5: Route code 2'b10 makes a group feed the sum of the owning cell's previous neighbour and no longer feed its owner.
- R6: Route code 2'b11 parks a group. It feeds no cell's sum.
- R7: If both groups of a cell carry the same lending code (2'b01 or 2'b10), only group 0 is lent. Group 1 is kept by its owner. A cell therefore receives at most one group, four terms, from each neighbour.
- R8: A cell's sum is 1 exactly when at least one of the four terms in at least one group reaching that cell is 1.
- R9: With `FOLDED`=1 and N cells per ring (N even, H=N/2), the next neighbour of local index i is i-1 for 0<i<H, H for i=0, i+1 for H<=i<N-1, and H-1 for i=N-1. The previous neighbour is the inverse map.
- R10: With `FOLDED`=0, the next neighbour of local index i is (i+1) mod N, and the previous neighbour is (i-1) mod N.
- R11: Ring r holds cells r*N to r*N+N-1. No group crosses between rings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pt_i | input | NUM_RINGS*RING_CELLS*8 (192) | Product-term results, two 4-term groups per cell |
| cfg_i | input | NUM_RINGS*RING_CELLS*4 (96) | Two-bit route code per group |
| sum_o | output | NUM_RINGS*RING_CELLS (24) | Registered OR of the groups reaching each cell |

## Verification
The assertions check every cycle the whole-array cases in which every route code is equal: all-keep must reproduce each cell's own terms, all-park and all-zero terms must give zero sums, and uniform lending in either direction must combine a cell's kept group 1 with the group 0 of the proper neighbour. Mixed configurations, the exact folded and sequential neighbour maps at the wrap points, ring isolation, the one-cycle latency and reset behaviour appear only in the bench's scenarios. There, a behavioural model builds the ring order independently and predicts every sum.

// File: rtl/ptal_pkg.sv
package ptal_pkg;

  localparam int unsigned GROUPS_PER_CELL = 2;
  localparam int unsigned ROUTE_W         = 2;

  typedef enum logic [1:0] {
    RT_KEEP    = 2'b00,
    RT_TO_NEXT = 2'b01,
    RT_TO_PREV = 2'b10,
    RT_PARK    = 2'b11
  } pt_route_e;

  // next neighbour of local index loc in a ring of n cells
  function automatic int unsigned ring_next(int unsigned loc, int unsigned n, bit folded);
    int unsigned h;
    h = n / 2;
    if (!folded) return (loc == n - 1) ? 0 : loc + 1;
    if (loc < h) return (loc == 0) ? h : loc - 1;
    return (loc == n - 1) ? h - 1 : loc + 1;
  endfunction

  // previous neighbour, inverse of ring_next
  function automatic int unsigned ring_prev(int unsigned loc, int unsigned n, bit folded);
    int unsigned h;
    h = n / 2;
    if (!folded) return (loc == 0) ? n - 1 : loc - 1;
    if (loc == h) return 0;
    if (loc < h) return (loc == h - 1) ? n - 1 : loc + 1;
    return loc - 1;
  endfunction

endpackage

// File: rtl/ptal_cell_route.sv
module ptal_cell_route
  import ptal_pkg::*;
#(
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned PT_W   = GROUPS_PER_CELL * GROUP_W,
  localparam int unsigned CFG_W  = GROUPS_PER_CELL * ROUTE_W
) (
  input  logic [PT_W-1:0]  pt_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             own_o,
  output logic             to_next_o,
  output logic             to_prev_o
);

  logic [GROUPS_PER_CELL-1:0] grp_any;
  pt_route_e                  route [GROUPS_PER_CELL];

  for (genvar g = 0; g < GROUPS_PER_CELL; g++) begin : g_any
    assign grp_any[g] = |pt_i[g*GROUP_W +: GROUP_W];
  end

  // group 0 wins a contested lending direction; group 1 falls back to keep
  always_comb begin
    route[0] = pt_route_e'(cfg_i[0 +: ROUTE_W]);
    route[1] = pt_route_e'(cfg_i[ROUTE_W +: ROUTE_W]);
    if ((route[1] == route[0]) && ((route[0] == RT_TO_NEXT) || (route[0] == RT_TO_PREV)))
      route[1] = RT_KEEP;
  end

  always_comb begin
    own_o     = 1'b0;
    to_next_o = 1'b0;
    to_prev_o = 1'b0;
    for (int g = 0; g < GROUPS_PER_CELL; g++) begin
      unique case (route[g])
        RT_KEEP:    own_o     = own_o     | grp_any[g];
        RT_TO_NEXT: to_next_o = to_next_o | grp_any[g];
        RT_TO_PREV: to_prev_o = to_prev_o | grp_any[g];
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/ptal_ring.sv
module ptal_ring
  import ptal_pkg::*;
#(
  parameter int unsigned CELLS   = 12,
  parameter bit          FOLDED  = 1'b1,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned PT_W   = GROUPS_PER_CELL * GROUP_W,
  localparam int unsigned CFG_W  = GROUPS_PER_CELL * ROUTE_W
) (
  input  logic [CELLS*PT_W-1:0]  pt_i,
  input  logic [CELLS*CFG_W-1:0] cfg_i,
  output logic [CELLS-1:0]       sum_o
);

  logic [CELLS-1:0] own;
  logic [CELLS-1:0] to_next;
  logic [CELLS-1:0] to_prev;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    localparam int unsigned NXT = ring_next(c, CELLS, FOLDED);
    localparam int unsigned PRV = ring_prev(c, CELLS, FOLDED);

    ptal_cell_route #(.GROUP_W(GROUP_W)) u_route (
      .pt_i      (pt_i[c*PT_W +: PT_W]),
      .cfg_i     (cfg_i[c*CFG_W +: CFG_W]),
      .own_o     (own[c]),
      .to_next_o (to_next[c]),
      .to_prev_o (to_prev[c])
    );

    // what the previous cell sends forward and the next cell sends back
    assign sum_o[c] = own[c] | to_next[PRV] | to_prev[NXT];
  end

endmodule

// File: rtl/ptal_alloc_ring.sv
module ptal_alloc_ring
  import ptal_pkg::*;
#(
  parameter int unsigned RING_CELLS = 12,
  parameter bit          FOLDED     = 1'b1,
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_RINGS  = 2
) (
  input  logic                                                   clk_i,
  input  logic                                                   rst_ni,
  input  logic [NUM_RINGS*RING_CELLS*GROUPS_PER_CELL*GROUP_W-1:0] pt_i,
  input  logic [NUM_RINGS*RING_CELLS*GROUPS_PER_CELL*ROUTE_W-1:0] cfg_i,
  output logic [NUM_RINGS*RING_CELLS-1:0]                        sum_o
);

  localparam int unsigned CELLS     = NUM_RINGS * RING_CELLS;
  localparam int unsigned PT_RING   = RING_CELLS * GROUPS_PER_CELL * GROUP_W;
  localparam int unsigned CFG_RING  = RING_CELLS * GROUPS_PER_CELL * ROUTE_W;

  logic [CELLS-1:0] sum_d;
  logic [CELLS-1:0] sum_q;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    ptal_ring #(
      .CELLS   (RING_CELLS),
      .FOLDED  (FOLDED),
      .GROUP_W (GROUP_W)
    ) u_ring (
      .pt_i  (pt_i[r*PT_RING +: PT_RING]),
      .cfg_i (cfg_i[r*CFG_RING +: CFG_RING]),
      .sum_o (sum_d[r*RING_CELLS +: RING_CELLS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/ptal_alloc_ring_chk.sv
module ptal_alloc_ring_chk
  import ptal_pkg::*;
#(
  parameter int unsigned RING_CELLS = 12,
  parameter bit          FOLDED     = 1'b1,
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_RINGS  = 2,
  localparam int unsigned CELLS     = NUM_RINGS * RING_CELLS,
  localparam int unsigned PTC       = GROUPS_PER_CELL * GROUP_W,
  localparam int unsigned CFC       = GROUPS_PER_CELL * ROUTE_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CELLS*PTC-1:0]   pt_i,
  input logic [CELLS*CFC-1:0]   cfg_i,
  input logic [CELLS-1:0]       sum_o
);

  localparam logic [CELLS*CFC-1:0] ALL_NEXT = {(CELLS*GROUPS_PER_CELL){2'b01}};
  localparam logic [CELLS*CFC-1:0] ALL_PREV = {(CELLS*GROUPS_PER_CELL){2'b10}};
  localparam logic [CELLS*CFC-1:0] ALL_PARK = {(CELLS*GROUPS_PER_CELL){2'b11}};

  p_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == ALL_PARK) |=> (sum_o == '0));

  p_zero_terms_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i == '0) |=> (sum_o == '0));

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    localparam int unsigned LOC  = k % RING_CELLS;
    localparam int unsigned BASE = k - LOC;
    localparam int unsigned NXT  = BASE + ring_next(LOC, RING_CELLS, FOLDED);
    localparam int unsigned PRV  = BASE + ring_prev(LOC, RING_CELLS, FOLDED);

    p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i == '0) |=> (sum_o[k] == $past(|pt_i[k*PTC +: PTC])));

    // uniform lending: group 0 moves, group 1 stays (R7)
    p_lend_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i == ALL_NEXT) |=>
        (sum_o[k] == $past((|pt_i[k*PTC+GROUP_W +: GROUP_W]) | (|pt_i[PRV*PTC +: GROUP_W]))));

    p_lend_prev_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i == ALL_PREV) |=>
        (sum_o[k] == $past((|pt_i[k*PTC+GROUP_W +: GROUP_W]) | (|pt_i[NXT*PTC +: GROUP_W]))));
  end

endmodule

bind ptal_alloc_ring ptal_alloc_ring_chk #(
  .RING_CELLS (RING_CELLS),
  .FOLDED     (FOLDED),
  .GROUP_W    (GROUP_W),
  .NUM_RINGS  (NUM_RINGS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pt_i   (pt_i),
  .cfg_i  (cfg_i),
  .sum_o  (sum_o)
);

// File: tb/tb_ptal_alloc_ring.sv
module tb_ptal_alloc_ring;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [191:0] pt_a = '0;
  logic [95:0]  cfg_a = '0;
  logic [23:0]  sum_a;
  logic [95:0]  pt_b = '0;
  logic [47:0]  cfg_b = '0;
  logic [11:0]  sum_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptal_alloc_ring dut (
    .clk_i(clk), .rst_ni(rst_n), .pt_i(pt_a), .cfg_i(cfg_a), .sum_o(sum_a)
  );

  ptal_alloc_ring #(.RING_CELLS(6), .FOLDED(1'b0)) dut_seq (
    .clk_i(clk), .rst_ni(rst_n), .pt_i(pt_b), .cfg_i(cfg_b), .sum_o(sum_b)
  );

  // ring order built as a walk: 0, H..N-1, H-1 down to 1
  function automatic int nxt_of(int loc, int n, bit fold);
    int ord[24];
    int k;
    int h;
    if (!fold) return (loc + 1) % n;
    h = n / 2;
    k = 0;
    ord[k] = 0;
    k = k + 1;
    for (int j = h; j < n; j++) begin ord[k] = j; k = k + 1; end
    for (int j = h - 1; j >= 1; j--) begin ord[k] = j; k = k + 1; end
    for (int j = 0; j < n; j++) if (ord[j] == loc) return ord[(j + 1) % n];
    return 0;
  endfunction

  function automatic int prv_of(int loc, int n, bit fold);
    for (int j = 0; j < n; j++) if (nxt_of(j, n, fold) == loc) return j;
    return 0;
  endfunction

  function automatic logic [23:0] model(logic [191:0] pt, logic [95:0] cfg,
                                        int cells, int n, bit fold);
    logic [23:0] e;
    e = '0;
    for (int c = 0; c < cells; c++) begin
      int base;
      int loc;
      logic [1:0] code [2];
      base = (c / n) * n;
      loc  = c % n;
      code[0] = cfg[c*4 +: 2];
      code[1] = cfg[c*4+2 +: 2];
      if (code[0] == code[1] && (code[0] == 2'b01 || code[0] == 2'b10)) code[1] = 2'b00;
      for (int g = 0; g < 2; g++) begin
        logic any;
        any = |pt[c*8+g*4 +: 4];
        case (code[g])
          2'b00: e[c] = e[c] | any;
          2'b01: e[base + nxt_of(loc, n, fold)] = e[base + nxt_of(loc, n, fold)] | any;
          2'b10: e[base + prv_of(loc, n, fold)] = e[base + prv_of(loc, n, fold)] | any;
          default: ;
        endcase
      end
    end
    return e;
  endfunction

  task automatic cmp_a(string tag, logic [23:0] exp);
    for (int c = 0; c < 24; c++) begin
      total++;
      if (sum_a[c] !== exp[c]) begin
        bad++;
        $display("FAIL %s folded cell %0d: got %b exp %b", tag, c, sum_a[c], exp[c]);
      end
    end
  endtask

  task automatic cmp_b(string tag, logic [11:0] exp);
    for (int c = 0; c < 12; c++) begin
      total++;
      if (sum_b[c] !== exp[c]) begin
        bad++;
        $display("FAIL %s sequential cell %0d: got %b exp %b", tag, c, sum_b[c], exp[c]);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_a(string tag);
    step();
    cmp_a(tag, model(pt_a, cfg_a, 24, 12, 1'b1));
  endtask

  task automatic run_b(string tag);
    logic [23:0] e;
    step();
    e = model({96'b0, pt_b}, {48'b0, cfg_b}, 12, 6, 1'b0);
    cmp_b(tag, e[11:0]);
  endtask

  initial begin
    logic [23:0] hold;
    logic [23:0] e;
    // R1: reset holds outputs at zero
    pt_a = '1;
    pt_b = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_a("R1", '0);
    cmp_b("R1", '0);
    rst_n = 1'b1;

    // R3 R8: single term kept by its owner
    pt_a = '0;
    pt_a[3*8+4+2] = 1'b1;
    run_a("R3 R8");
    e = '0; e[3] = 1'b1;
    cmp_a("R3 explicit", e);

    // R4 R9: cell 0 group 0 lent next -> cell 6
    pt_a = '0; pt_a[0] = 1'b1;
    cfg_a = '0; cfg_a[1:0] = 2'b01;
    run_a("R4 R9");
    e = '0; e[6] = 1'b1;
    cmp_a("R4 explicit", e);

    // R5 R9: cell 0 group 1 lent previous -> cell 1
    pt_a = '0; pt_a[4] = 1'b1;
    cfg_a = '0; cfg_a[3:2] = 2'b10;
    run_a("R5 R9");
    e = '0; e[1] = 1'b1;
    cmp_a("R5 explicit", e);

    // R9 R11: wrap points of both rings
    pt_a = '0; pt_a[11*8] = 1'b1; pt_a[12*8+4] = 1'b1; pt_a[23*8] = 1'b1;
    cfg_a = '0; cfg_a[11*4 +: 2] = 2'b01; cfg_a[12*4+2 +: 2] = 2'b10; cfg_a[23*4 +: 2] = 2'b01;
    run_a("R9 R11");
    e = '0; e[5] = 1'b1; e[13] = 1'b1; e[17] = 1'b1;
    cmp_a("R11 explicit", e);

    // R6: parked groups reach nobody
    pt_a = '1;
    cfg_a = '1;
    run_a("R6");

    // R7: contested direction, group 1 stays home
    pt_a = '0; pt_a[2*8+4 +: 4] = 4'b1000;
    cfg_a = '0; cfg_a[2*4 +: 4] = 4'b0101;
    run_a("R7 kept");
    e = '0; e[2] = 1'b1;
    cmp_a("R7 explicit", e);
    pt_a = '0; pt_a[2*8] = 1'b1;
    run_a("R7 lent");
    e = '0; e[1] = 1'b1;
    cmp_a("R7 lent explicit", e);

    // R2: no change before the edge
    hold = sum_a;
    pt_a = '0; pt_a[5*8+1] = 1'b1;
    cfg_a = '0;
    #1;
    cmp_a("R2 hold", hold);
    run_a("R2 update");

    // R10: sequential wrap, cell 5 next -> cell 0, cell 0 prev -> cell 5
    pt_b = '0; pt_b[5*8] = 1'b1;
    cfg_b = '0; cfg_b[5*4 +: 2] = 2'b01;
    run_b("R10");
    pt_b = '0; pt_b[4] = 1'b1;
    cfg_b = '0; cfg_b[2 +: 2] = 2'b10;
    run_b("R10 prev");

    // R8 R9 R10: random mixes
    for (int i = 0; i < 300; i++) begin
      for (int w = 0; w < 6; w++) begin
        pt_a[w*32 +: 32] = $urandom() & $urandom() & $urandom();
      end
      for (int w = 0; w < 3; w++) begin
        pt_b[w*32 +: 32] = $urandom() & $urandom() & $urandom();
        cfg_a[w*32 +: 32] = $urandom();
      end
      cfg_b = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      step();
      cmp_a("R8 R9 random", model(pt_a, cfg_a, 24, 12, 1'b1));
      e = model({96'b0, pt_b}, {48'b0, cfg_b}, 12, 6, 1'b0);
      cmp_b("R8 R10 random", e[11:0]);
    end

    // R1: asynchronous reset mid-run
    pt_a = '1; cfg_a = '0;
    step();
    rst_n = 1'b0;
    #1;
    cmp_a("R1 async", '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule